// File: doc/BRIEF.md
# Write-Back Cache State Controller with Degraded Error Mode

This block keeps the coherence state and address tags of a direct-mapped write-back cache whose lines are 32 bytes. It decides the outcome of each processor lookup and handles incoming bus coherence requests. Each line is in one of three states: empty, clean (read-only, possibly shared with other caches), or dirty (owned for writing by this cache alone). Before a clean line may be written, write ownership must be obtained again through a fill. The data array, the error-correcting code and the bus signalling are outside this block. The fill, write-back and ownership transactions are assumed to be carried out by neighbouring logic, using the strobes this block produces.

When a serious hardware fault is reported, or software raises its control bit, the block enters a degraded error mode. The cache is not switched off. Dirty lines keep being served, because they hold the only valid copy of their data. Clean lines and misses are sent around the cache to memory, and nothing is allocated. Coherence requests from the bus continue to be answered exactly as in normal operation, so no dirty data is stranded. Software uses the control bit to hold the cache in this mode while an error is being serviced, and lowers it to leave.

Top module: `wbc_txn_cache`

## Requirements
- R1: After reset every line is empty, all response and strobe outputs are low, `tmode_active` is low, and the first lookup of any address answers miss.
- R2: In normal mode a lookup answers exactly one of hit, miss or bypass one cycle later. A read hitting a clean or dirty line is a hit. A write hitting a dirty line is a hit. Any other lookup is a miss that allocates the line, clean for a read and dirty for a write. A write to a clean line is therefore a miss that leaves the line dirty.
- R3: A miss whose victim is a dirty line with a different tag pulses `evict_wb` in the response cycle, with `evict_addr` set to the victim's line-aligned address. A clean or empty victim gives no eviction.
- R4: Coherence requests use `co_kind` 0 for invalidate and 1 for write-back request, and `snoop_done` pulses one cycle later. An invalidate empties a present line and pulses `snoop_wb` if the line was dirty. A write-back request to a dirty line pulses `snoop_wb` and leaves the line clean. All other cases change nothing. `snoop_addr` carries the request's line-aligned address.
- R5: When a lookup and a coherence request address the same set in the same cycle, the lookup is decided against the line state left by the coherence request.
- R6: Raising `err_uncorr`, `err_bus_par` or `err_xact_fail`, or holding `sw_tmode` high, makes `tmode_active` high from the next cycle.
- R7: `err_corr` alone neither enters degraded mode nor alters any line.
- R8: While `tmode_active` is high, a lookup that hits a dirty line is a hit. A lookup that hits a clean line, or that misses, answers bypass. No line is allocated or changed by the lookup, and `evict_wb` stays low.
- R9: While `tmode_active` is high, coherence requests behave exactly as in R4.
- R10: Degraded mode is left only in the cycle after `sw_tmode` falls from 1 to 0 with no error line asserted (the correctable line included). In every other case it is held, including after a hardware entry while `sw_tmode` stays low.
- R11: Lines present before degraded mode keep their tags and states. After leaving the mode, a clean line that was bypassed hits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Processor lookup present this cycle |
| lk_write | input | 1 | Lookup is a write |
| lk_addr | input | ADDR_W | Lookup byte address |
| co_valid | input | 1 | Bus coherence request present |
| co_kind | input | 1 | 0 invalidate, 1 write-back request |
| co_addr | input | ADDR_W | Coherence request byte address |
| err_uncorr | input | 1 | Uncorrectable cache error event |
| err_corr | input | 1 | Corrected cache error event |
| err_bus_par | input | 1 | Parity error on the processor-to-cache interface |
| err_xact_fail | input | 1 | Failed ownership or write-back transaction |
| sw_tmode | input | 1 | Software degraded-mode control bit |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Served from the cache |
| rsp_miss | output | 1 | Fill needed; line allocated |
| rsp_bypass | output | 1 | Sent to memory without allocation |
| evict_wb | output | 1 | Dirty victim must be written back |
| evict_addr | output | ADDR_W | Victim line address |
| snoop_done | output | 1 | Coherence request handled |
| snoop_wb | output | 1 | Dirty data must be supplied to the bus |
| snoop_addr | output | ADDR_W | Line address of the coherence write-back |
| tmode_active | output | 1 | Degraded error mode in force |

## Verification
Lookup and coherence responses appear one clock after the request is sampled. An error line or a control-bit change shows on `tmode_active` one clock after it is driven, and a lookup presented in that same cycle still sees the old mode. Every bench scenario drives its inputs just after a falling edge and lets exactly one rising edge pass. It then reads the outputs at the following falling edge and removes the stimulus before the next rising edge. Each result is therefore compared in the one cycle it is due, and later lookups reveal whether a stimulus touched line state it should have left alone.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        BLK_INV = 2'b00,
        BLK_RO  = 2'b01,
        BLK_WR  = 2'b10
    } blk_state_e;

    typedef enum logic [1:0] {
        LK_NONE   = 2'b00,
        LK_HIT    = 2'b01,
        LK_FILL   = 2'b10,
        LK_BYPASS = 2'b11
    } lk_res_e;

    typedef enum logic {
        CO_INVAL = 1'b0,
        CO_WBREQ = 1'b1
    } co_op_e;

    typedef struct packed {
        lk_res_e    res;
        logic       alloc;
        blk_state_e nst;
    } lk_dec_t;

    typedef struct packed {
        logic       upd;
        logic       wb;
        blk_state_e nst;
    } co_dec_t;

    // Outcome of a processor lookup against one line
    function automatic lk_dec_t lk_decide(input logic present, input blk_state_e st,
                                          input logic wr, input logic tmode);
        lk_dec_t d;
        d.res   = LK_NONE;
        d.alloc = 1'b0;
        d.nst   = st;
        if (tmode) begin
            d.res = (present && st == BLK_WR) ? LK_HIT : LK_BYPASS;
        end else if (present && (st == BLK_WR || !wr)) begin
            d.res = LK_HIT;
        end else begin
            d.res   = LK_FILL;
            d.alloc = 1'b1;
            d.nst   = wr ? BLK_WR : BLK_RO;
        end
        return d;
    endfunction

    // Outcome of a bus coherence request against one line
    function automatic co_dec_t co_decide(input logic present, input blk_state_e st,
                                          input co_op_e op);
        co_dec_t d;
        d.upd = 1'b0;
        d.wb  = 1'b0;
        d.nst = st;
        if (present) begin
            if (op == CO_INVAL) begin
                d.upd = 1'b1;
                d.wb  = (st == BLK_WR);
                d.nst = BLK_INV;
            end else if (st == BLK_WR) begin
                d.upd = 1'b1;
                d.wb  = 1'b1;
                d.nst = BLK_RO;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/wbc_mode_ctl.sv
module wbc_mode_ctl (
    input  logic clk,
    input  logic rst,
    input  logic err_uncorr,
    input  logic err_corr,
    input  logic err_bus_par,
    input  logic err_xact_fail,
    input  logic sw_req,
    output logic tmode
);
    logic hard_err;
    logic any_err;
    logic sw_q;
    logic leave;
    logic tmode_q;
    logic tmode_d;

    assign hard_err = err_uncorr | err_bus_par | err_xact_fail;
    assign any_err  = hard_err | err_corr;
    // exit only on a falling control bit with every error line quiet
    assign leave    = sw_q & ~sw_req & ~any_err;
    assign tmode_d  = hard_err | sw_req | (tmode_q & ~leave);

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q    <= 1'b0;
            tmode_q <= 1'b0;
        end else begin
            sw_q    <= sw_req;
            tmode_q <= tmode_d;
        end
    end

    assign tmode = tmode_q;
endmodule

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
    import wbc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [TAG_W-1:0] rd_a_tag,
    output blk_state_e       rd_a_st,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [TAG_W-1:0] rd_b_tag,
    output blk_state_e       rd_b_st,
    input  logic             wr_a_en,
    input  logic [IDX_W-1:0] wr_a_idx,
    input  logic [TAG_W-1:0] wr_a_tag,
    input  blk_state_e       wr_a_st,
    input  logic             wr_b_en,
    input  logic [IDX_W-1:0] wr_b_idx,
    input  blk_state_e       wr_b_st
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    blk_state_e       st_q  [SETS];
    logic [SETS-1:0]  sel_a;
    logic [SETS-1:0]  sel_b;

    generate
        for (genvar g = 0; g < SETS; g++) begin : g_sel
            assign sel_a[g] = wr_a_en && (wr_a_idx == IDX_W'(g));
            assign sel_b[g] = wr_b_en && (wr_b_idx == IDX_W'(g));
        end
    endgenerate

    // port A (lookup) wins a same-set collision: its state already includes port B's effect
    always_ff @(posedge clk) begin
        for (int i = 0; i < SETS; i++) begin
            if (rst) begin
                tag_q[i] <= '0;
                st_q[i]  <= BLK_INV;
            end else if (sel_a[i]) begin
                tag_q[i] <= wr_a_tag;
                st_q[i]  <= wr_a_st;
            end else if (sel_b[i]) begin
                st_q[i]  <= wr_b_st;
            end
        end
    end

    assign rd_a_tag = tag_q[rd_a_idx];
    assign rd_a_st  = st_q[rd_a_idx];
    assign rd_b_tag = tag_q[rd_b_idx];
    assign rd_b_st  = st_q[rd_b_idx];
endmodule

// File: rtl/wbc_snoop_unit.sv
module wbc_snoop_unit
    import wbc_pkg::*;
#(
    parameter int TAG_W = 21
) (
    input  logic             co_valid,
    input  co_op_e           co_kind,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  blk_state_e       line_st,
    output logic             upd,
    output blk_state_e       nst,
    output logic             wb
);
    co_dec_t d;
    logic    present;

    assign present = (line_st != BLK_INV) && (line_tag == req_tag);
    assign d       = co_decide(present, line_st, co_kind);
    assign upd     = co_valid & d.upd;
    assign wb      = co_valid & d.wb;
    assign nst     = d.nst;
endmodule

// File: rtl/wbc_lookup_unit.sv
module wbc_lookup_unit
    import wbc_pkg::*;
#(
    parameter int TAG_W = 21
) (
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic             tmode,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  blk_state_e       line_st,
    output lk_res_e          res,
    output logic             we,
    output blk_state_e       nst,
    output logic             evict
);
    lk_dec_t d;
    logic    tag_eq;
    logic    present;

    assign tag_eq  = (line_tag == req_tag);
    assign present = (line_st != BLK_INV) && tag_eq;
    assign d       = lk_decide(present, line_st, lk_write, tmode);
    assign res     = lk_valid ? d.res : LK_NONE;
    assign we      = lk_valid & d.alloc;
    assign nst     = d.nst;
    assign evict   = we && (line_st == BLK_WR) && !tag_eq;
endmodule

// File: rtl/wbc_txn_cache.sv
module wbc_txn_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SETS      = 64,
    parameter int BLK_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              co_valid,
    input  logic              co_kind,
    input  logic [ADDR_W-1:0] co_addr,
    input  logic              err_uncorr,
    input  logic              err_corr,
    input  logic              err_bus_par,
    input  logic              err_xact_fail,
    input  logic              sw_tmode,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_bypass,
    output logic              evict_wb,
    output logic [ADDR_W-1:0] evict_addr,
    output logic              snoop_done,
    output logic              snoop_wb,
    output logic [ADDR_W-1:0] snoop_addr,
    output logic              tmode_active
);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] co_idx;
    logic [TAG_W-1:0] co_tag;
    logic             unused_off;

    assign lk_idx     = lk_addr[OFF_W +: IDX_W];
    assign lk_tag     = lk_addr[ADDR_W-1 -: TAG_W];
    assign co_idx     = co_addr[OFF_W +: IDX_W];
    assign co_tag     = co_addr[ADDR_W-1 -: TAG_W];
    assign unused_off = ^{lk_addr[OFF_W-1:0], co_addr[OFF_W-1:0]};

    logic tmode;

    wbc_mode_ctl u_mode (
        .clk           (clk),
        .rst           (rst),
        .err_uncorr    (err_uncorr),
        .err_corr      (err_corr),
        .err_bus_par   (err_bus_par),
        .err_xact_fail (err_xact_fail),
        .sw_req        (sw_tmode),
        .tmode         (tmode)
    );

    logic [TAG_W-1:0] lk_line_tag;
    blk_state_e       lk_line_st;
    logic [TAG_W-1:0] co_line_tag;
    blk_state_e       co_line_st;
    logic             lk_we;
    blk_state_e       lk_nst;
    logic             co_upd;
    blk_state_e       co_nst;
    logic             co_wb;
    lk_res_e          lk_res;
    logic             lk_evict;
    blk_state_e       lk_st_eff;

    wbc_tag_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (lk_idx),
        .rd_a_tag (lk_line_tag),
        .rd_a_st  (lk_line_st),
        .rd_b_idx (co_idx),
        .rd_b_tag (co_line_tag),
        .rd_b_st  (co_line_st),
        .wr_a_en  (lk_we),
        .wr_a_idx (lk_idx),
        .wr_a_tag (lk_tag),
        .wr_a_st  (lk_nst),
        .wr_b_en  (co_upd),
        .wr_b_idx (co_idx),
        .wr_b_st  (co_nst)
    );

    wbc_snoop_unit #(
        .TAG_W (TAG_W)
    ) u_snoop (
        .co_valid (co_valid),
        .co_kind  (co_op_e'(co_kind)),
        .req_tag  (co_tag),
        .line_tag (co_line_tag),
        .line_st  (co_line_st),
        .upd      (co_upd),
        .nst      (co_nst),
        .wb       (co_wb)
    );

    // coherence request is ordered ahead of a same-set lookup in the same cycle
    assign lk_st_eff = (co_upd && co_idx == lk_idx) ? co_nst : lk_line_st;

    wbc_lookup_unit #(
        .TAG_W (TAG_W)
    ) u_lookup (
        .lk_valid (lk_valid),
        .lk_write (lk_write),
        .tmode    (tmode),
        .req_tag  (lk_tag),
        .line_tag (lk_line_tag),
        .line_st  (lk_st_eff),
        .res      (lk_res),
        .we       (lk_we),
        .nst      (lk_nst),
        .evict    (lk_evict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_bypass <= 1'b0;
            evict_wb   <= 1'b0;
            evict_addr <= '0;
            snoop_done <= 1'b0;
            snoop_wb   <= 1'b0;
            snoop_addr <= '0;
        end else begin
            rsp_valid  <= (lk_res != LK_NONE);
            rsp_hit    <= (lk_res == LK_HIT);
            rsp_miss   <= (lk_res == LK_FILL);
            rsp_bypass <= (lk_res == LK_BYPASS);
            evict_wb   <= lk_evict;
            evict_addr <= {lk_line_tag, lk_idx, {OFF_W{1'b0}}};
            snoop_done <= co_valid;
            snoop_wb   <= co_wb;
            snoop_addr <= {co_tag, co_idx, {OFF_W{1'b0}}};
        end
    end

    assign tmode_active = tmode;
endmodule

// File: rtl/wbc_txn_cache_chk.sv
module wbc_txn_cache_chk (
    input logic clk,
    input logic rst,
    input logic lk_valid,
    input logic co_valid,
    input logic err_uncorr,
    input logic err_corr,
    input logic err_bus_par,
    input logic err_xact_fail,
    input logic sw_tmode,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_miss,
    input logic rsp_bypass,
    input logic evict_wb,
    input logic snoop_done,
    input logic snoop_wb,
    input logic tmode_active
);
    logic hard;
    logic any_err;
    assign hard    = err_uncorr | err_bus_par | err_xact_fail;
    assign any_err = hard | err_corr;

    // R2
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_bypass}) == 1));

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R3
    evict_with_miss_chk: assert property (@(posedge clk) disable iff (rst)
        evict_wb |-> rsp_miss);

    // R4
    snoop_latency_chk: assert property (@(posedge clk) disable iff (rst)
        co_valid |=> snoop_done);

    // R4
    snoop_wb_done_chk: assert property (@(posedge clk) disable iff (rst)
        snoop_wb |-> snoop_done);

    // R6
    hard_entry_chk: assert property (@(posedge clk) disable iff (rst)
        hard |=> tmode_active);

    // R7
    corr_no_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (err_corr && !hard && !sw_tmode && !tmode_active) |=> !tmode_active);

    // R8
    tmode_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && tmode_active) |=> (!rsp_miss && !evict_wb));

    // R10
    exit_rule_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tmode_active) |-> (!$past(sw_tmode) && $past(sw_tmode, 2) && !$past(any_err)));
endmodule

bind wbc_txn_cache wbc_txn_cache_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .co_valid      (co_valid),
    .err_uncorr    (err_uncorr),
    .err_corr      (err_corr),
    .err_bus_par   (err_bus_par),
    .err_xact_fail (err_xact_fail),
    .sw_tmode      (sw_tmode),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_miss      (rsp_miss),
    .rsp_bypass    (rsp_bypass),
    .evict_wb      (evict_wb),
    .snoop_done    (snoop_done),
    .snoop_wb      (snoop_wb),
    .tmode_active  (tmode_active)
);

// File: tb/tb_wbc_txn_cache.sv
`timescale 1ns/1ps
module tb_wbc_txn_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic        lk_write = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        co_valid = 1'b0;
    logic        co_kind = 1'b0;
    logic [31:0] co_addr = '0;
    logic        err_uncorr = 1'b0;
    logic        err_corr = 1'b0;
    logic        err_bus_par = 1'b0;
    logic        err_xact_fail = 1'b0;
    logic        sw_tmode = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_bypass;
    logic        evict_wb, snoop_done, snoop_wb, tmode_active;
    logic [31:0] evict_addr, snoop_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [2:0] HIT = 3'b100;
    localparam logic [2:0] MIS = 3'b010;
    localparam logic [2:0] BYP = 3'b001;
    localparam logic INV_OP = 1'b0;
    localparam logic WBR_OP = 1'b1;

    // set 0: A, B   set 1: C   set 2: D, F   set 3: E   set 5: X   set 6: Y
    localparam logic [31:0] A = 32'h0000_1000;
    localparam logic [31:0] B = 32'h0000_2000;
    localparam logic [31:0] C = 32'h0000_1020;
    localparam logic [31:0] D = 32'h0000_1040;
    localparam logic [31:0] E = 32'h0000_3060;
    localparam logic [31:0] F = 32'h0000_5040;
    localparam logic [31:0] X = 32'h0000_10A0;
    localparam logic [31:0] Y = 32'h0000_10C0;

    always #2 clk = ~clk;

    wbc_txn_cache dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_addr(lk_addr),
        .co_valid(co_valid), .co_kind(co_kind), .co_addr(co_addr),
        .err_uncorr(err_uncorr), .err_corr(err_corr),
        .err_bus_par(err_bus_par), .err_xact_fail(err_xact_fail),
        .sw_tmode(sw_tmode),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_bypass(rsp_bypass), .evict_wb(evict_wb), .evict_addr(evict_addr),
        .snoop_done(snoop_done), .snoop_wb(snoop_wb), .snoop_addr(snoop_addr),
        .tmode_active(tmode_active)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_rsp(input string req, input logic [2:0] hmb,
                             input logic ev, input logic [31:0] ev_a);
        chk(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(req, "hit/miss/bypass", {29'd0, rsp_hit, rsp_miss, rsp_bypass}, {29'd0, hmb});
        chk(req, "evict_wb", {31'd0, evict_wb}, {31'd0, ev});
        if (ev) chk(req, "evict_addr", evict_addr, ev_a);
    endtask

    task automatic check_snoop(input string req, input logic wb, input logic [31:0] a);
        chk(req, "snoop_done", {31'd0, snoop_done}, 32'd1);
        chk(req, "snoop_wb", {31'd0, snoop_wb}, {31'd0, wb});
        if (wb) chk(req, "snoop_addr", snoop_addr, a);
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic wr,
                          input logic [2:0] hmb, input logic ev, input logic [31:0] ev_a);
        lk_valid = 1'b1; lk_addr = a; lk_write = wr;
        step();
        lk_valid = 1'b0; lk_write = 1'b0;
        check_rsp(req, hmb, ev, ev_a);
    endtask

    task automatic snoop(input string req, input logic [31:0] a, input logic kind,
                         input logic wb);
        co_valid = 1'b1; co_addr = a; co_kind = kind;
        step();
        co_valid = 1'b0;
        check_snoop(req, wb, a);
    endtask

    task automatic chk_mode(input string req, input logic exp);
        chk(req, "tmode_active", {31'd0, tmode_active}, {31'd0, exp});
    endtask

    task automatic sw_exit(input string req);
        sw_tmode = 1'b1; step();
        sw_tmode = 1'b0; step();
        chk_mode(req, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1", "evict_wb", {31'd0, evict_wb}, 32'd0);
        chk("R1", "snoop_done", {31'd0, snoop_done}, 32'd0);
        chk_mode("R1", 1'b0);
        lookup("R1", A, 1'b0, MIS, 1'b0, 0);
    endtask

    task automatic t_normal();
        lookup("R2", A + 32'h4, 1'b0, HIT, 1'b0, 0);
        lookup("R2", A, 1'b1, MIS, 1'b0, 0);
        lookup("R2", A, 1'b1, HIT, 1'b0, 0);
        lookup("R2", A, 1'b0, HIT, 1'b0, 0);
    endtask

    task automatic t_evict();
        lookup("R3", B, 1'b0, MIS, 1'b1, A);
        lookup("R3", A + 32'h1C, 1'b0, MIS, 1'b0, 0);
    endtask

    task automatic t_snoop();
        lookup("R4", C, 1'b1, MIS, 1'b0, 0);
        snoop("R4", C, WBR_OP, 1'b1);
        lookup("R4", C, 1'b0, HIT, 1'b0, 0);
        lookup("R4", C, 1'b1, MIS, 1'b0, 0);
        snoop("R4", A, INV_OP, 1'b0);
        lookup("R4", A, 1'b0, MIS, 1'b0, 0);
        snoop("R4", E, INV_OP, 1'b0);
        snoop("R4", A, WBR_OP, 1'b0);
    endtask

    task automatic t_collide();
        lookup("R5", X, 1'b0, MIS, 1'b0, 0);
        lk_valid = 1'b1; lk_addr = X; lk_write = 1'b0;
        co_valid = 1'b1; co_addr = X; co_kind = INV_OP;
        step();
        lk_valid = 1'b0; co_valid = 1'b0;
        check_rsp("R5", MIS, 1'b0, 0);
        check_snoop("R5", 1'b0, X);
        lookup("R5", Y, 1'b1, MIS, 1'b0, 0);
        lk_valid = 1'b1; lk_addr = Y; lk_write = 1'b1;
        co_valid = 1'b1; co_addr = Y; co_kind = WBR_OP;
        step();
        lk_valid = 1'b0; lk_write = 1'b0; co_valid = 1'b0;
        check_rsp("R5", MIS, 1'b0, 0);
        check_snoop("R5", 1'b1, Y);
    endtask

    task automatic t_corr();
        lookup("R7", D, 1'b1, MIS, 1'b0, 0);
        err_corr = 1'b1; step(); err_corr = 1'b0;
        chk_mode("R7", 1'b0);
        step();
        chk_mode("R7", 1'b0);
        lookup("R7", A, 1'b0, HIT, 1'b0, 0);
        lookup("R7", D, 1'b1, HIT, 1'b0, 0);
    endtask

    task automatic t_hard_entry();
        err_uncorr = 1'b1; step(); err_uncorr = 1'b0;
        chk_mode("R6", 1'b1);
    endtask

    task automatic t_tmode_lookup();
        lookup("R8", D, 1'b0, HIT, 1'b0, 0);
        lookup("R8", D, 1'b1, HIT, 1'b0, 0);
        lookup("R8", A, 1'b0, BYP, 1'b0, 0);
        lookup("R8", A, 1'b1, BYP, 1'b0, 0);
        lookup("R8", E, 1'b0, BYP, 1'b0, 0);
        lookup("R8", E, 1'b0, BYP, 1'b0, 0);
        lookup("R8", F, 1'b1, BYP, 1'b0, 0);
        lookup("R8", D, 1'b0, HIT, 1'b0, 0);
    endtask

    task automatic t_tmode_snoop();
        snoop("R9", C, INV_OP, 1'b1);
        lookup("R9", C, 1'b0, BYP, 1'b0, 0);
        snoop("R9", D, WBR_OP, 1'b1);
        lookup("R9", D, 1'b0, BYP, 1'b0, 0);
        chk_mode("R9", 1'b1);
    endtask

    task automatic t_exit();
        step(); step(); step();
        chk_mode("R10", 1'b1);
        sw_tmode = 1'b1; step();
        chk_mode("R10", 1'b1);
        sw_tmode = 1'b0; err_bus_par = 1'b1; step(); err_bus_par = 1'b0;
        chk_mode("R10", 1'b1);
        step();
        chk_mode("R10", 1'b1);
        sw_tmode = 1'b1; step();
        sw_tmode = 1'b0; err_corr = 1'b1; step(); err_corr = 1'b0;
        chk_mode("R10", 1'b1);
        step();
        chk_mode("R10", 1'b1);
        sw_exit("R10");
    endtask

    task automatic t_preserve();
        lookup("R11", A, 1'b0, HIT, 1'b0, 0);
        lookup("R11", D, 1'b0, HIT, 1'b0, 0);
        lookup("R11", Y, 1'b1, HIT, 1'b0, 0);
        lookup("R11", E, 1'b0, MIS, 1'b0, 0);
    endtask

    task automatic t_other_entry();
        sw_tmode = 1'b1; step();
        chk_mode("R6", 1'b1);
        lookup("R6", E, 1'b0, BYP, 1'b0, 0);
        sw_tmode = 1'b0; step();
        chk_mode("R6", 1'b0);
        err_xact_fail = 1'b1; step(); err_xact_fail = 1'b0;
        chk_mode("R6", 1'b1);
        sw_exit("R6");
        err_bus_par = 1'b1; step(); err_bus_par = 1'b0;
        chk_mode("R6", 1'b1);
        sw_exit("R6");
        lookup("R6", E, 1'b0, HIT, 1'b0, 0);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) step();
        rst = 1'b0;
        step();
        t_reset();
        t_normal();
        t_evict();
        t_snoop();
        t_collide();
        t_corr();
        t_hard_entry();
        t_tmode_lookup();
        t_tmode_snoop();
        t_exit();
        t_preserve();
        t_other_entry();
        step();
        finish_run();
    end
endmodule